// File: doc/BRIEF.md
# Quad-SPI Instruction Fetch Sequencer

This block sits between a small processor core and a serial NOR flash that holds the program. After reset it wakes the flash, enables writes, sets the quad-enable bit in the status registers, and then opens a continuous quad-I/O read. Once the read is open, it clocks the flash without pause. It gathers four nibbles into each 16-bit instruction and presents the instruction on a parallel output, with a one-cycle strobe for each word.

The core changes the fetch address by pulsing `branch_req` with a word address. If the read is already past its command byte, the sequencer drops chip select, discards any half-built word, and opens a new quad read at byte address twice the word address. If the request arrives earlier, the sequencer only records the address, and the first read uses it.

The serial clock runs at half the system clock and idles low. The controller changes its outgoing data only on falling edges of the serial clock. It samples the flash on rising edges. Chip select stays high for `CS_GAP` system cycles before every transaction.

Top module: `qspi_fetch_seq`

## Requirements
- R1: While reset is held, `spi_cs_n` is 1, `spi_sck` is 0, `spi_d_oe` is 4'b0000, `fetch_done` is 0 and `instr` is 0.
- R2: Before every transaction, `spi_cs_n` stays high for exactly `CS_GAP` clock cycles. The first transaction after reset is excluded. `spi_sck` is 0 whenever `spi_cs_n` is high.
- R3: In single-line phases, bits go out MSB first on lane 0, and `spi_d_oe` is 4'b1101 (bit n enables lane n). Lanes 2 and 3 are driven to 1, and lane 1 is released for the flash.
- R4: After reset the preamble is four transactions, each framed by chip select, in this order: {FFh}, {ABh}, {06h}, {01h, 02h, 02h}.
- R5: Each read transaction sends EBh on a single line. It then sends seven bytes on all four lanes with `spi_d_oe` = 4'b1111, high nibble first: three address bytes (most significant first, equal to twice the word address), three 00h bytes, and A5h.
- R6: While `spi_cs_n` is low, `spi_sck` toggles every clock cycle. `spi_d_out` and `spi_d_oe` change only on cycles where `spi_sck` falls.
- R7: After A5h, chip select stays low and `spi_d_oe` is 4'b0000. A nibble is taken from `spi_d_in` at each rising serial edge. The first byte received forms `instr[15:8]` (big-endian), and each byte is high nibble first.
- R8: `fetch_done` is a one-cycle pulse, high in the cycle after the fourth nibble of a word is sampled, and `instr` carries that word. `instr` does not change while `fetch_done` is low.
- R9: A `branch_req` during the read phase drives `spi_cs_n` high in the next cycle and discards the partial word without a `fetch_done` pulse. After the gap, the sequencer reopens the read at the new word address.
- R10: A `branch_req` before the address bytes of a read have started changes only the stored address. The ongoing transaction continues, and the next address bytes carry the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| branch_req | input | 1 | One-cycle request to restart fetching at `branch_addr` |
| branch_addr | input | ADDR_W | Word address for the restart |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock, half the system clock |
| spi_d_out | output | 4 | Values driven onto the four flash data lanes |
| spi_d_oe | output | 4 | Per-lane output enable, 1 = drive |
| spi_d_in | input | 4 | Values read back from the four flash data lanes |
| instr | output | WORD_W | Most recently assembled instruction word |
| fetch_done | output | 1 | One-cycle strobe when `instr` is updated |

## Verification
The embedded assertions check on every cycle that:
- the serial clock idles while chip select is high and toggles every cycle while it is low;
- the lanes are released whenever a word completes;
- quad lane enables are all-or-nothing;
- the strobe is a single cycle and `instr` holds between strobes;
- a branch in the read phase raises chip select with no strobe.

Only the bench scenarios show the rest:
- the byte contents and order of the preamble and read commands;
- the exact chip-select gap;
- the address carried after an early or late branch;
- the big-endian word values assembled from a modelled flash, at several branch phases relative to word boundaries.

// File: rtl/qfs_pkg.sv
package qfs_pkg;
  typedef enum logic [1:0] {
    ST_GAP  = 2'd0,
    ST_XFER = 2'd1,
    ST_READ = 2'd2
  } qfs_state_e;

  // Step indices into the command stream; the order is the wire order.
  localparam logic [3:0] STEP_EB   = 4'd6;
  localparam logic [3:0] STEP_ADDR = 4'd7;
  localparam logic [3:0] STEP_LAST = 4'd13;
endpackage

// File: rtl/qfs_cmd_rom.sv
// Byte to transmit for each command step, plus its lane mode and framing.
module qfs_cmd_rom
  import qfs_pkg::*;
(
  input  logic [3:0]  step,
  input  logic [23:0] byte_addr,
  output logic [7:0]  cmd_byte,
  output logic        quad,
  output logic        ends_tx
);
  always_comb begin
    unique case (step)
      4'd0:    cmd_byte = 8'hFF;
      4'd1:    cmd_byte = 8'hAB;
      4'd2:    cmd_byte = 8'h06;
      4'd3:    cmd_byte = 8'h01;
      4'd4:    cmd_byte = 8'h02;
      4'd5:    cmd_byte = 8'h02;
      4'd6:    cmd_byte = 8'hEB;
      4'd7:    cmd_byte = byte_addr[23:16];
      4'd8:    cmd_byte = byte_addr[15:8];
      4'd9:    cmd_byte = byte_addr[7:0];
      4'd13:   cmd_byte = 8'hA5;
      default: cmd_byte = 8'h00;
    endcase
  end

  assign quad    = (step >= STEP_ADDR);
  assign ends_tx = (step == 4'd0) || (step == 4'd1) || (step == 4'd2) || (step == 4'd5);
endmodule

// File: rtl/qfs_lane_drv.sv
// Per-lane output value and enable for single-line and quad phases.
module qfs_lane_drv #(
  parameter int LANES = 4
) (
  input  logic             active,
  input  logic             quad,
  input  logic [7:0]       cmd_byte,
  input  logic [2:0]       bit_idx,
  output logic [LANES-1:0] d_out,
  output logic [LANES-1:0] d_oe
);
  logic [3:0] nib;
  logic       serial_bit;

  assign nib        = bit_idx[0] ? cmd_byte[3:0] : cmd_byte[7:4];
  assign serial_bit = cmd_byte[3'd7 - bit_idx];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_si
      assign d_out[g] = active & (quad ? nib[g] : serial_bit);
      assign d_oe[g]  = active;
    end else if (g == 1) begin : g_so
      assign d_out[g] = active & quad & nib[g];
      assign d_oe[g]  = active & quad;
    end else begin : g_ctl
      assign d_out[g] = active & (quad ? nib[g] : 1'b1);
      assign d_oe[g]  = active;
    end
  end
endmodule

// File: rtl/qfs_word_asm.sv
// Shifts in nibbles, high first, and publishes a word every WORD_W/4 nibbles.
module qfs_word_asm #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic [3:0]        nib,
  output logic [WORD_W-1:0] word,
  output logic              done
);
  localparam int NIBS = WORD_W / 4;
  localparam int NC_W = (NIBS > 1) ? $clog2(NIBS) : 1;

  logic [WORD_W-5:0] sh_q, sh_d;
  logic [NC_W-1:0]   ncnt_q, ncnt_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              done_d;

  always_comb begin
    sh_d   = sh_q;
    ncnt_d = ncnt_q;
    word_d = word_q;
    done_d = 1'b0;
    if (clr) begin
      ncnt_d = '0;
    end else if (cap) begin
      sh_d = {sh_q[WORD_W-9:0], nib};
      if (ncnt_q == NC_W'(NIBS - 1)) begin
        ncnt_d = '0;
        word_d = {sh_q, nib};
        done_d = 1'b1;
      end else begin
        ncnt_d = ncnt_q + NC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      ncnt_q <= '0;
      word_q <= '0;
      done   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      ncnt_q <= ncnt_d;
      word_q <= word_d;
      done   <= done_d;
    end
  end

  assign word = word_q;

  // R8: a strobe always follows a capture cycle
  a_r8_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cap));
endmodule

// File: rtl/qspi_fetch_seq.sv
module qspi_fetch_seq
  import qfs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 16,
  parameter int CS_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              branch_req,
  input  logic [ADDR_W-1:0] branch_addr,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic [3:0]        spi_d_out,
  output logic [3:0]        spi_d_oe,
  input  logic [3:0]        spi_d_in,
  output logic [WORD_W-1:0] instr,
  output logic              fetch_done
);
  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);

  logic rs1_q, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_s <= rs1_q;
    end
  end

  qfs_state_e        state_q, state_d;
  logic [3:0]        step_q, step_d;
  logic [2:0]        bit_q, bit_d;
  logic              sck_q, sck_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;

  logic [23:0] byte_addr;
  logic [7:0]  cmd_byte;
  logic        quad, ends_tx, restart;
  logic [2:0]  last_bit;

  assign byte_addr = 24'({waddr_q, 1'b0});
  assign last_bit  = quad ? 3'd1 : 3'd7;
  assign restart   = (state_q == ST_READ) || ((state_q == ST_XFER) && (step_q >= STEP_ADDR));

  qfs_cmd_rom u_rom (
    .step      (step_q),
    .byte_addr (byte_addr),
    .cmd_byte  (cmd_byte),
    .quad      (quad),
    .ends_tx   (ends_tx)
  );

  qfs_lane_drv #(.LANES(4)) u_lanes (
    .active   (state_q == ST_XFER),
    .quad     (quad),
    .cmd_byte (cmd_byte),
    .bit_idx  (bit_q),
    .d_out    (spi_d_out),
    .d_oe     (spi_d_oe)
  );

  qfs_word_asm #(.WORD_W(WORD_W)) u_asm (
    .clk   (clk),
    .rst_n (rst_s),
    .clr   ((state_q != ST_READ) || branch_req),
    .cap   ((state_q == ST_READ) && !sck_q && !branch_req),
    .nib   (spi_d_in),
    .word  (instr),
    .done  (fetch_done)
  );

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    bit_d   = bit_q;
    sck_d   = sck_q;
    gap_d   = gap_q;
    waddr_d = waddr_q;
    unique case (state_q)
      ST_GAP: begin
        sck_d = 1'b0;
        if (gap_q == GAP_LAST) begin
          state_d = ST_XFER;
          gap_d   = '0;
          bit_d   = '0;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      ST_XFER: begin
        sck_d = ~sck_q;
        if (sck_q) begin
          if (bit_q == last_bit) begin
            bit_d = '0;
            if (ends_tx) begin
              state_d = ST_GAP;
              gap_d   = '0;
              step_d  = step_q + 4'd1;
            end else if (step_q == STEP_LAST) begin
              state_d = ST_READ;
            end else begin
              step_d = step_q + 4'd1;
            end
          end else begin
            bit_d = bit_q + 3'd1;
          end
        end
      end
      ST_READ: sck_d = ~sck_q;
      default: state_d = ST_GAP;
    endcase
    if (branch_req) begin
      waddr_d = branch_addr;
      if (restart) begin
        state_d = ST_GAP;
        gap_d   = '0;
        sck_d   = 1'b0;
        bit_d   = '0;
        step_d  = STEP_EB;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_GAP;
      step_q  <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b0;
      gap_q   <= '0;
      waddr_q <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      bit_q   <= bit_d;
      sck_q   <= sck_d;
      gap_q   <= gap_d;
      waddr_q <= waddr_d;
    end
  end

  assign spi_cs_n = (state_q == ST_GAP);
  assign spi_sck  = sck_q;

  // R2: serial clock idles low while deselected
  a_r2_sck_idle: assert property (@(posedge clk) disable iff (!rst_s)
    spi_cs_n |-> !spi_sck);
  // R6: serial clock toggles every cycle while selected
  a_r6_sck_toggle: assert property (@(posedge clk) disable iff (!rst_s)
    (!spi_cs_n && $past(!spi_cs_n)) |-> (spi_sck != $past(spi_sck)));
  // R5: lane 1 is driven only together with all other lanes
  a_r5_quad_lanes: assert property (@(posedge clk) disable iff (!rst_s)
    spi_d_oe[1] |-> (spi_d_oe == 4'hF));
  // R7: lanes are released whenever a word has just been assembled
  a_r7_released: assert property (@(posedge clk) disable iff (!rst_s)
    fetch_done |-> (spi_d_oe == 4'h0));
  // R8: strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    fetch_done |=> !fetch_done);
  // R8: word holds between strobes
  a_r8_instr_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !fetch_done |-> $stable(instr));
  // R9: branch while reading deselects at once and drops the partial word
  a_r9_branch_drop: assert property (@(posedge clk) disable iff (!rst_s)
    (branch_req && (state_q == ST_READ)) |=> (spi_cs_n && !fetch_done));
endmodule

// File: tb/tb_qspi_fetch_seq.sv
module tb_qspi_fetch_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 16;
  localparam int CS_GAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic branch_req = 1'b0;
  logic [ADDR_W-1:0] branch_addr = '0;
  logic [3:0] spi_d_in = 4'h0;
  logic spi_cs_n, spi_sck, fetch_done;
  logic [3:0] spi_d_out, spi_d_oe;
  logic [WORD_W-1:0] instr;

  qspi_fetch_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CS_GAP(CS_GAP)) dut (
    .clk(clk), .rst_n(rst_n), .branch_req(branch_req), .branch_addr(branch_addr),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_d_out(spi_d_out), .spi_d_oe(spi_d_oe),
    .spi_d_in(spi_d_in), .instr(instr), .fetch_done(fetch_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [15:0] mem_word(input int unsigned a);
    logic [31:0] t;
    t = (a * 32'h0000A3B1) ^ 32'h00005C3E;
    return t[15:0] ^ t[31:16];
  endfunction

  function automatic logic [7:0] mem_byte(input int unsigned b);
    logic [15:0] w;
    w = mem_word(b >> 1);
    return b[0] ? w[7:0] : w[15:8];
  endfunction

  function automatic logic [7:0] exp_byte(input int tx, input int k, input int unsigned a);
    logic [31:0] ba;
    ba = a * 2;
    if (tx == 0) return 8'hFF;
    if (tx == 1) return 8'hAB;
    if (tx == 2) return 8'h06;
    if (tx == 3) return (k == 0) ? 8'h01 : 8'h02;
    case (k)
      0: return 8'hEB;
      1: return ba[23:16];
      2: return ba[15:8];
      3: return ba[7:0];
      7: return 8'hA5;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int exp_len(input int tx);
    if (tx < 3) return 1;
    if (tx == 3) return 3;
    return 8;
  endfunction

  // flash / reference model state
  int mode = 0;             // 0 deselected, 1 command, 2 read, 3 awaiting deselect
  int tx = 0;
  int bk = 0;
  int bitc = 0;
  bit quadm = 1'b0;
  logic [7:0] cur = 8'h00;
  int unsigned exp_addr = 0;
  int unsigned fptr = 0;
  int nib_i = 0;
  bit pend = 1'b0;
  bit exp_fd = 1'b0;
  logic [15:0] pend_w = 16'h0;
  logic [15:0] exp_instr = 16'h0;
  bit prev_cs = 1'b1;
  bit prev_sck = 1'b0;
  logic [3:0] prev_do = 4'h0;
  logic [3:0] prev_oe = 4'h0;
  int hi_cnt = 0;
  bit seen_low = 1'b0;
  bit cs_chk = 1'b0;
  int words = 0;
  bit br_want = 1'b0;
  bit br_pre = 1'b0;
  logic [ADDR_W-1:0] br_target = '0;
  logic [7:0] fb;

  always @(negedge clk) begin
    if (rst_n) begin
      branch_req <= 1'b0;
      // R7, R8: strobe and word against the model
      exp_fd = pend;
      pend = 1'b0;
      if (exp_fd) begin
        exp_instr = pend_w;
        words++;
      end
      check(fetch_done == exp_fd, "R8 fetch_done", 32'(fetch_done), 32'(exp_fd));
      check(instr == exp_instr, "R7 instr big-endian word", 32'(instr), 32'(exp_instr));
      if (cs_chk) begin
        check(spi_cs_n == 1'b1, "R9 deselect after branch", 32'(spi_cs_n), 32'd1);
        cs_chk = 1'b0;
      end
      if (spi_cs_n) begin
        check(spi_sck == 1'b0, "R2 sck idle", 32'(spi_sck), 32'd0);
        hi_cnt++;
        if (!prev_cs) begin
          if (mode == 1) check(bk == exp_len(tx), "R4 transaction length", 32'(bk), 32'(exp_len(tx)));
          tx++;
          mode = 0;
        end
      end else begin
        if (prev_cs) begin
          if (seen_low) check(hi_cnt == CS_GAP, "R2 chip-select gap", 32'(hi_cnt), 32'(CS_GAP));
          seen_low = 1'b1;
          hi_cnt = 0;
          mode = 1;
          bk = 0;
          bitc = 0;
          quadm = 1'b0;
          cur = 8'h00;
        end else begin
          check(spi_sck != prev_sck, "R6 sck toggle", 32'(spi_sck), 32'(!prev_sck));
          if (spi_sck) begin
            check(spi_d_out == prev_do, "R6 data launched on falling edge", 32'(spi_d_out), 32'(prev_do));
            check(spi_d_oe == prev_oe, "R6 enable launched on falling edge", 32'(spi_d_oe), 32'(prev_oe));
          end
        end
        if (mode == 2) check(spi_d_oe == 4'h0, "R7 lanes released", 32'(spi_d_oe), 32'd0);
        if (mode == 1 && spi_sck && !prev_sck && !prev_cs) begin
          if (!quadm) begin
            check(spi_d_oe == 4'b1101, "R3 single-line enables", 32'(spi_d_oe), 32'hD);
            check(spi_d_out[3:2] == 2'b11, "R3 lanes 2,3 high", 32'(spi_d_out[3:2]), 32'h3);
            cur = {cur[6:0], spi_d_out[0]};
            bitc += 1;
          end else begin
            check(spi_d_oe == 4'hF, "R5 quad enables", 32'(spi_d_oe), 32'hF);
            cur = {cur[3:0], spi_d_out};
            bitc += 4;
          end
          if (bitc == 8) begin
            bitc = 0;
            if (tx < 4)
              check(cur == exp_byte(tx, bk, exp_addr), "R4 preamble byte", 32'(cur), 32'(exp_byte(tx, bk, exp_addr)));
            else
              check(cur == exp_byte(tx, bk, exp_addr), "R5 R10 read command byte", 32'(cur), 32'(exp_byte(tx, bk, exp_addr)));
            bk++;
            if (tx >= 4 && bk == 1) quadm = 1'b1;
            if (tx >= 4 && bk == 8) begin
              mode = 2;
              fptr = exp_addr * 2;
              nib_i = 0;
            end
          end
        end
        if (br_want && br_pre && mode == 1 && tx == 0) begin
          branch_req <= 1'b1;
          branch_addr <= br_target;
          exp_addr = br_target;
          br_want = 1'b0;
        end else if (br_want && !br_pre && mode == 2) begin
          branch_req <= 1'b1;
          branch_addr <= br_target;
          exp_addr = br_target;
          br_want = 1'b0;
          mode = 3;
          cs_chk = 1'b1;
        end else if (mode == 2 && !spi_sck) begin
          fb = mem_byte(fptr + nib_i / 2);
          spi_d_in <= (nib_i % 2 == 0) ? fb[7:4] : fb[3:0];
          if (nib_i % 4 == 3) begin
            pend = 1'b1;
            pend_w = mem_word(fptr / 2 + nib_i / 4);
          end
          nib_i++;
        end
      end
      prev_cs = spi_cs_n;
      prev_sck = spi_sck;
      prev_do = spi_d_out;
      prev_oe = spi_d_oe;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(spi_cs_n == 1'b1, "R1 cs_n", 32'(spi_cs_n), 32'd1);
    check(spi_sck == 1'b0, "R1 sck", 32'(spi_sck), 32'd0);
    check(spi_d_oe == 4'h0, "R1 oe", 32'(spi_d_oe), 32'd0);
    check(fetch_done == 1'b0, "R1 fetch_done", 32'(fetch_done), 32'd0);
    check(instr == '0, "R1 instr", 32'(instr), 32'd0);
    br_pre = 1'b1;
    br_target = 16'h0123;
    br_want = 1'b1;
    rst_n = 1'b1;
    // R10: early branch during the first preamble transaction
    while (br_want) @(posedge clk);
    while (words < 4) @(posedge clk);
    br_pre = 1'b0;
    for (int i = 0; i < 5; i++) begin
      int w0;
      @(posedge clk);
      case (i)
        0: br_target = 16'h0040;
        1: br_target = 16'hFFFF;
        2: br_target = 16'h0000;
        3: br_target = 16'h1234;
        default: br_target = 16'h8001;
      endcase
      br_want = 1'b1;  // R9: restart at a new word address
      while (br_want) @(posedge clk);
      w0 = words;
      while (words < w0 + 3 + i) @(posedge clk);
      repeat (i) @(posedge clk);
    end
    repeat (10) @(posedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", words, 0);
    summary();
    $finish;
  end
endmodule